// File: doc/BRIEF.md
# Grouped GPIO Interrupt Aggregator

This block collects interrupt requests from a large bank of general-purpose input pins and folds them onto a single parent interrupt line. Every pin owns a small configuration word. It chooses edge or level sensing and the polarity or edge kind. It also holds an interrupt enable, a separate unmask bit and a wake enable. Beside these sit two sticky flags, one for interrupt status and one for wake status, and software clears each flag by writing a one to it. Inputs are assumed to be debounced and synchronous to the clock already.

To find the source of an interrupt quickly, software first reads a summary vector that carries one bit per group of four neighbouring pins. The vector is spread over two 32-bit words. Software then visits only the flagged groups. The parent line gives one pulse and then disarms itself. It fires again only after software writes the end-of-service bit in the master word. With that bit, software sets the point at which a new notification may be raised.

Access is through a plain single-cycle register port. Pin words sit at word addresses 0 to NUM_PINS-1, and three control words sit at the top of the address space.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, every pin word reads with configuration and both status flags at zero, both summary words read zero, the master word reads 2 (armed, bit 1 set), and irq_out is low.
- R2: A pin word holds these fields: bit 0 selects level sensing (1) or edge sensing (0), bits 2:1 hold the polarity code, bit 3 is interrupt enable, bit 4 is unmask (1 = unmasked) and bit 5 is wake enable. A write sets all six fields, which read back unchanged. Bit 8 reads the pin's present input level.
- R3: In level mode, code 00 latches interrupt status while the input is low and code 01 latches it while the input is high. Status stays set after the input goes inactive. If software clears it while the input is still active, it reads 0 right after the clearing write and is set again one clock later.
- R4: In edge mode, code 00 latches on a falling transition, 01 on a rising transition and 10 on either transition. A steady input never latches status.
- R5: Code 11 never latches status in either mode. Code 10 never latches in level mode.
- R6: Interrupt status (bit 12) latches only when interrupt enable is 1. Wake status (bit 13) latches on the same detection when wake enable is 1, whatever interrupt enable holds.
- R7: Writing a pin word with bit 12 set clears interrupt status, and writing it with bit 13 set clears wake status. A status bit written as 0 is left as it is.
- R8: Summary bit n is 1 when any of pins 4n to 4n+3 has interrupt or wake status set. Address 252 returns summary bits 31:0. Address 253 returns bits 45:32 in its bits 13:0, with zeros above.
- R9: When the block is armed and some pin has interrupt status, enable and unmask all at 1, irq_out gives a single-cycle pulse and the block disarms. No further pulse follows while it stays disarmed, even if status remains pending.
- R10: A pin whose unmask bit is 0 never causes a pulse, although its status still latches and still shows in the summary.
- R11: Writing address 254 with bit 0 set re-arms the block, and a pulse follows at once if a qualifying pin is still pending. Bit 1 of address 254 reads the armed state.
- R12: Addresses from NUM_PINS to 251, and address 255, read zero, and writes to them change no pin, summary or master state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_PINS | Debounced pin input levels |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Word address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Parent interrupt pulse |

## Verification
The hardest situation to reach is a level-sensed pin that is cleared while its input is still active. The status must read 0 in the cycle directly after the clearing write and must be set again one clock later. To see this, the bench samples the pin word immediately after the write edge and then once more a cycle later. A sweep over every sensing mode, polarity code and input transition on one pin computes each expected flag from the requirement table. A second sweep raises each of the 184 pins in turn and checks that exactly one summary bit, in the correct word, responds. A final pass holds a pin pending across an end-of-service write to show that the parent line fires exactly once per arming.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;

    localparam int WORD_W     = 32;
    localparam int CFG_W      = 6;
    localparam int BIT_PIN    = 8;
    localparam int BIT_INT_ST = 12;
    localparam int BIT_WAKE_ST = 13;
    localparam int BIT_EOI    = 0;
    localparam int BIT_ARMED  = 1;

    // polarity / edge-kind selection
    typedef enum logic [1:0] {
        POL_LOW_FALL  = 2'b00,
        POL_HIGH_RISE = 2'b01,
        POL_ANY_EDGE  = 2'b10,
        POL_RESERVED  = 2'b11
    } pol_e;

    // per-pin configuration, packed in register bit order [5:0]
    typedef struct packed {
        logic wake_en;   // bit 5
        logic unmask;    // bit 4
        logic irq_en;    // bit 3
        pol_e pol;       // bits 2:1
        logic lvl_mode;  // bit 0
    } pin_cfg_t;

    function automatic pin_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.wake_en  = w[5];
        c.unmask   = w[4];
        c.irq_en   = w[3];
        c.pol      = pol_e'(w[2:1]);
        c.lvl_mode = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cell_to_word(input pin_cfg_t c,
                                                       input logic pin_lvl,
                                                       input logic int_st,
                                                       input logic wake_st);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFG_W-1:0]   = c;
        w[BIT_PIN]     = pin_lvl;
        w[BIT_INT_ST]  = int_st;
        w[BIT_WAKE_ST] = wake_st;
        return w;
    endfunction

    // detection of one pin given present and previous sampled level
    function automatic logic detect_hit(input pin_cfg_t c, input logic cur,
                                        input logic prev);
        logic hit;
        hit = 1'b0;
        if (c.lvl_mode) begin
            case (c.pol)
                POL_LOW_FALL:  hit = !cur;
                POL_HIGH_RISE: hit = cur;
                default:       hit = 1'b0;
            endcase
        end else begin
            case (c.pol)
                POL_LOW_FALL:  hit = prev && !cur;
                POL_HIGH_RISE: hit = !prev && cur;
                POL_ANY_EDGE:  hit = prev ^ cur;
                default:       hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_i,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_d,
    input  logic     clr_int,
    input  logic     clr_wake,
    output pin_cfg_t cfg_q,
    output logic     int_sts,
    output logic     wake_sts
);

    logic prev_q;
    logic hit;

    assign hit = detect_hit(cfg_q, pin_i, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            cfg_q    <= '0;
            int_sts  <= 1'b0;
            wake_sts <= 1'b0;
        end else begin
            prev_q <= pin_i;
            if (cfg_we)
                cfg_q <= cfg_d;
            // a clear wins its cycle; a still-active level sets again next cycle
            if (clr_int)
                int_sts <= 1'b0;
            else if (hit && cfg_q.irq_en)
                int_sts <= 1'b1;
            if (clr_wake)
                wake_sts <= 1'b0;
            else if (hit && cfg_q.wake_en)
                wake_sts <= 1'b1;
        end
    end

    assert_clear_int_R7: assert property (@(posedge clk) disable iff (rst)
        clr_int |=> !int_sts);

    assert_clear_wake_R7: assert property (@(posedge clk) disable iff (rst)
        clr_wake |=> !wake_sts);

    assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(int_sts) && !$past(cfg_q.lvl_mode)) |-> ($past(pin_i) != $past(prev_q)));

    assert_reserved_silent_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(int_sts) || $rose(wake_sts)) |-> ($past(cfg_q.pol) != POL_RESERVED));

    assert_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(int_sts) |-> $past(cfg_q.irq_en));

endmodule

// File: rtl/gpio_group_summary.sv
module gpio_group_summary #(
    parameter int NUM_PINS   = 184,
    parameter int GROUP_SZ   = 4,
    parameter int NUM_GROUPS = (NUM_PINS + GROUP_SZ - 1) / GROUP_SZ
) (
    input  logic [NUM_PINS-1:0]   flags,
    output logic [NUM_GROUPS-1:0] grp
);

    localparam int PAD_W = NUM_GROUPS * GROUP_SZ;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(flags);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp[g] = |padded[g*GROUP_SZ +: GROUP_SZ];
    end

endmodule

// File: rtl/gpio_parent_gate.sv
module gpio_parent_gate (
    input  logic clk,
    input  logic rst,
    input  logic pend_any,
    input  logic eoi,
    output logic irq_out,
    output logic armed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b1;
            irq_out <= 1'b0;
        end else begin
            irq_out <= armed && pend_any;
            if (eoi)
                armed <= 1'b1;
            else if (armed && pend_any)
                armed <= 1'b0;
        end
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !$past(eoi)) |=> !irq_out);

    assert_disarm_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> irq_out);

    assert_eoi_rearms_R11: assert property (@(posedge clk) disable iff (rst)
        eoi |=> armed);

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_agg_pkg::*;
#(
    parameter int NUM_PINS = 184,
    parameter int GROUP_SZ = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] gpio_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq_out
);

    // NUM_GROUPS must not exceed 64 and NUM_PINS must stay below ADDR_SUM_LO
    localparam int NUM_GROUPS    = (NUM_PINS + GROUP_SZ - 1) / GROUP_SZ;
    localparam int ADDR_SUM_LO   = (1 << ADDR_W) - 4;
    localparam int ADDR_SUM_HI   = (1 << ADDR_W) - 3;
    localparam int ADDR_MASTER   = (1 << ADDR_W) - 2;

    logic [NUM_PINS-1:0]   int_flags;
    logic [NUM_PINS-1:0]   wake_flags;
    logic [NUM_PINS-1:0]   pend_vec;
    logic [WORD_W-1:0]     pin_words [NUM_PINS];
    logic [NUM_GROUPS-1:0] grp_sum;
    logic [63:0]           sum64;
    pin_cfg_t              wr_cfg;
    logic                  eoi_wr;
    logic                  armed;

    assign wr_cfg = word_to_cfg(reg_wdata);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic     sel;
        pin_cfg_t cfg;

        assign sel = reg_wr && (reg_addr == ADDR_W'(p));

        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .pin_i    (gpio_in[p]),
            .cfg_we   (sel),
            .cfg_d    (wr_cfg),
            .clr_int  (sel && reg_wdata[BIT_INT_ST]),
            .clr_wake (sel && reg_wdata[BIT_WAKE_ST]),
            .cfg_q    (cfg),
            .int_sts  (int_flags[p]),
            .wake_sts (wake_flags[p])
        );

        assign pend_vec[p]  = int_flags[p] && cfg.irq_en && cfg.unmask;
        assign pin_words[p] = cell_to_word(cfg, gpio_in[p], int_flags[p], wake_flags[p]);
    end

    gpio_group_summary #(
        .NUM_PINS   (NUM_PINS),
        .GROUP_SZ   (GROUP_SZ),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_summary (
        .flags (int_flags | wake_flags),
        .grp   (grp_sum)
    );

    assign sum64  = 64'(grp_sum);
    assign eoi_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_MASTER)) && reg_wdata[BIT_EOI];

    gpio_parent_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .pend_any (|pend_vec),
        .eoi      (eoi_wr),
        .irq_out  (irq_out),
        .armed    (armed)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (reg_addr == ADDR_W'(i))
                reg_rdata = pin_words[i];
        end
        if (reg_addr == ADDR_W'(ADDR_SUM_LO))
            reg_rdata = sum64[31:0];
        else if (reg_addr == ADDR_W'(ADDR_SUM_HI))
            reg_rdata = sum64[63:32];
        else if (reg_addr == ADDR_W'(ADDR_MASTER))
            reg_rdata = 32'(armed) << BIT_ARMED;
    end

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:14], reg_wdata[11:6]};

    assert_summary_any_R8: assert property (@(posedge clk) disable iff (rst)
        (|grp_sum) == (|(int_flags | wake_flags)));

    assert_hole_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_addr) >= NUM_PINS && int'(reg_addr) < ADDR_SUM_LO) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_gpio_irq_agg.sv
module sim_gpio_irq_agg;

    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] gpio_in = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    int hi_cyc  = 0;
    logic last_irq = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_agg u0 (
        .clk       (clk),
        .rst       (rst),
        .gpio_in   (gpio_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (irq_out) hi_cyc <= hi_cyc + 1;
            if (irq_out && !last_irq) pulses <= pulses + 1;
            last_irq <= irq_out;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = 8'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        reg_addr = 8'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // expected detection from the requirement table
    function automatic logic hit_of(input int lvl, input int pol, input logic cur, input logic prev);
        if (lvl != 0) return (pol == 0) ? !cur : (pol == 1) ? cur : 1'b0;
        if (pol == 0) return prev && !cur;
        if (pol == 1) return !prev && cur;
        if (pol == 2) return prev ^ cur;
        return 1'b0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] sexp;
        logic        e1, e2, e3;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, d);   check("R1 pin0", d, 32'h0);
        rd(183, d); check("R1 pin183", d, 32'h0);
        rd(252, d); check("R1 sum lo", d, 32'h0);
        rd(253, d); check("R1 sum hi", d, 32'h0);
        rd(254, d); check("R1 master", d, 32'h2);
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // R2 field readback and pin level bit 8
        wr(7, 32'h3F);
        rd(7, d); check("R2 cfg readback", d, 32'h3F);
        @(negedge clk); gpio_in[7] = 1'b1;
        rd(7, d); check("R2 pin level", d, 32'h13F);
        gpio_in[7] = 1'b0;
        wr(7, 32'h0);

        // R3 R4 R5 sweep on pin 9: mode x code x start x end
        for (int lv = 0; lv < 2; lv++) begin
            for (int pc = 0; pc < 4; pc++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int e = 0; e < 2; e++) begin
                        logic [31:0] cfgw;
                        cfgw = 32'(lv) | (32'(pc) << 1) | 32'h8;
                        @(negedge clk); gpio_in[9] = s[0];
                        wr(9, cfgw | 32'h1000);
                        rd(9, d);
                        e1 = hit_of(lv, pc, s[0], s[0]);
                        check("R3/R4/R5 steady input", {31'b0, d[12]}, {31'b0, e1});
                        gpio_in[9] = e[0];
                        rd(9, d);
                        e2 = e1 | hit_of(lv, pc, e[0], s[0]);
                        check("R3/R4/R5 after transition", {31'b0, d[12]}, {31'b0, e2});
                        wr(9, cfgw | 32'h1000);
                        peek(9, d);
                        check("R7 cleared at once", {31'b0, d[12]}, 32'h0);
                        rd(9, d);
                        e3 = hit_of(lv, pc, e[0], e[0]);
                        check("R3 level re-set after clear", {31'b0, d[12]}, {31'b0, e3});
                    end
                end
            end
        end
        wr(9, 32'h1000);
        gpio_in[9] = 1'b0;
        wr(9, 32'h1000);

        // R6 wake without interrupt enable, summary R8 group 5
        @(negedge clk); gpio_in[20] = 1'b1;
        wr(20, 32'h23);
        rd(20, d); check("R6 int stays clear", {31'b0, d[12]}, 32'h0);
        check("R6 wake latched", {31'b0, d[13]}, 32'h1);
        rd(252, d); check("R8 wake in summary", d, 32'h20);
        gpio_in[20] = 1'b0;
        wr(20, 32'h0000);
        rd(20, d); check("R7 zero leaves wake", {31'b0, d[13]}, 32'h1);
        wr(20, 32'h2000);
        rd(20, d); check("R7 clear wake", {31'b0, d[13]}, 32'h0);

        // R8 R10 sweep over every pin, masked level-high
        for (int p = 0; p < NP; p++) begin
            @(negedge clk); gpio_in[p] = 1'b1;
            wr(p, 32'hB);
            rd(252, d); sexp = 64'h1 << (p / 4);
            check("R8 summary lo", d, sexp[31:0]);
            rd(253, d); check("R8 summary hi", d, sexp[63:32]);
            gpio_in[p] = 1'b0;
            wr(p, 32'h1000);
        end
        rd(252, d); check("R8 summary lo drained", d, 32'h0);
        check("R10 masked pins no pulse", 32'(pulses), 32'h0);

        // R9 R11 parent pulse and re-arm
        @(negedge clk); gpio_in[130] = 1'b1;
        wr(130, 32'h1B);
        idle(3);
        check("R9 one pulse", 32'(pulses), 32'h1);
        rd(254, d); check("R11 disarmed read", d, 32'h0);
        idle(10);
        check("R9 no repeat while disarmed", 32'(pulses), 32'h1);
        wr(254, 32'h1);
        idle(3);
        check("R11 re-arm fires pending", 32'(pulses), 32'h2);
        check("R9 single-cycle width", 32'(hi_cyc), 32'h2);
        gpio_in[130] = 1'b0;
        wr(130, 32'h101B);
        wr(254, 32'h1);
        idle(3);
        check("R11 no pulse after drain", 32'(pulses), 32'h2);
        rd(254, d); check("R11 armed read", d, 32'h2);

        // R12 holes
        wr(200, 32'hFFFF_FFFF);
        wr(255, 32'hFFFF_FFFF);
        rd(200, d); check("R12 hole 200", d, 32'h0);
        rd(251, d); check("R12 hole 251", d, 32'h0);
        rd(255, d); check("R12 hole 255", d, 32'h0);
        rd(183, d); check("R12 pin183 untouched", d, 32'h0);
        rd(252, d); check("R12 summary untouched", d, 32'h0);
        rd(254, d); check("R12 master untouched", d, 32'h2);
        check("R12 no pulse", 32'(pulses), 32'h2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule